// File: doc/BRIEF.md
# Flash Erase and Program Sequencer

This block sits behind a command decoder and turns single-cycle command strobes into operations on a byte-wide flash array model. The model has two partitions of equal size. The sequencer can erase one page, erase a whole partition, program one byte and read one byte. It keeps track of which partition is selected and holds a write-enable flag. The flag must be set before any erase or program is allowed.

The array is modelled as synchronous RAM. An erased byte reads as FFh, and programming can only clear bits. Flash timing limits are enforced in hardware. Every accepted erase holds `busy` high for `ERASE_CYC` clock cycles, and every accepted byte program holds it high for `PROG_CYC` cycles. Any command that arrives while `busy` is high is dropped, and a sticky error flag records it. An erase walks through its region, writing FFh one byte per cycle, while `busy` is high. For this reason `ERASE_CYC` must be at least the number of bytes in one partition.

Top module: `flash_seq_top`

## Requirements
- R1: After reset, `busy`, `err`, `wren_flag`, `part_sel` and `rdata` are all zero, and partition 0 is selected.
- R2: Only the low `ADDR_W` bits of `cmd_addr` select a byte. The upper bits have no effect on which byte is programmed or read.
- R3: Program (`cmd_op`=6) is accepted only when the sequencer is idle and the write-enable flag is set. It stores old AND `cmd_data` at the addressed byte of the selected partition, and it holds `busy` high for exactly `PROG_CYC` cycles.
- R4: Page erase (`cmd_op`=4) sets to FFh the 2^`PAGE_W` bytes whose page number is `cmd_addr[ADDR_W-1:PAGE_W]`, in the selected partition. If `cmd_addr[PAGE_W-1:0]` is non-zero, the command is rejected, `err` is set and no byte changes.
- R5: Partition erase (`cmd_op`=5) sets every byte of the selected partition to FFh and leaves the other partition unchanged.
- R6: An accepted erase holds `busy` high for exactly `ERASE_CYC` cycles. Any non-zero `cmd_op` strobed while `busy` is high is dropped and sets `err`. `err` stays set until a software reset is accepted.
- R7: Select-high (`cmd_op`=2) selects partition 1, and select-low (`cmd_op`=3) selects partition 0. Reads, programs and erases act on the selected partition.
- R8: Read (`cmd_op`=7) loads the addressed byte of the selected partition into `rdata`. The value is present on `rdata` in the second cycle after the strobe, and it is held until the next read.
- R9: Write-enable (`cmd_op`=1) sets `wren_flag`. An erase or program strobed while `wren_flag` is low is rejected, sets `err` and leaves the array unchanged.
- R10: Software reset (`cmd_op`=8), when accepted, clears `wren_flag` and `err` and selects partition 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command strobe, one cycle per command |
| cmd_op | input | 4 | Operation code (0 none, 1 write-enable, 2 select partition 1, 3 select partition 0, 4 page erase, 5 partition erase, 6 program, 7 read, 8 software reset) |
| cmd_addr | input | 16 | Byte address; bits above `ADDR_W` are ignored |
| cmd_data | input | 8 | Program data |
| busy | output | 1 | High while an erase or program interval is running |
| err | output | 1 | Sticky flag for rejected commands |
| wren_flag | output | 1 | Write-enable flag |
| part_sel | output | 1 | Selected partition |
| rdata | output | 8 | Byte returned by the last read |

## Verification
The bench checks the exact length of the busy window. A timer that is off by one would make the measured count differ from `ERASE_CYC` or `PROG_CYC`. It strobes a partition switch while an erase is running. A design that fails to drop that command would move `part_sel` and then erase or read the wrong partition. It programs twice with overlapping patterns and uses address upper bits that are not zero. This exposes a plain overwrite instead of an AND, and it exposes address decoding that folds in the upper bits. Misaligned page erases and erases without write-enable must leave every byte as it was. A full read-back of both partitions after each step reveals any stray write, including an erase that crosses into the other partition or the next page.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

  typedef enum logic [3:0] {
    OP_NOP      = 4'd0,
    OP_WREN     = 4'd1,
    OP_SEL_HI   = 4'd2,
    OP_SEL_LO   = 4'd3,
    OP_PG_ERASE = 4'd4,
    OP_PT_ERASE = 4'd5,
    OP_PROG     = 4'd6,
    OP_READ     = 4'd7,
    OP_SWRST    = 4'd8
  } op_e;

  typedef enum logic [1:0] {
    WK_IDLE = 2'd0,
    WK_PAGE = 2'd1,
    WK_PART = 2'd2
  } walk_e;

  localparam int unsigned NUM_PART = 2;

endpackage

// File: rtl/flash_bank.sv
module flash_bank #(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              we,
  input  logic              fill,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);

  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // storage array: erase fills with ones, program clears bits only
  always_ff @(posedge clk) begin
    if (en && we) begin
      if (fill) mem[addr] <= '1;
      else      mem[addr] <= mem[addr] & wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata <= '0;
    end else if (en && !we) begin
      rdata <= mem[addr];
    end
  end

endmodule

// File: rtl/flash_busy_timer.sv
module flash_busy_timer #(
  parameter int unsigned CNT_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             busy
);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load) begin
      cnt_d = load_val;
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign busy = (cnt_q != '0);

endmodule

// File: rtl/flash_seq_ctrl.sv
module flash_seq_ctrl
  import flash_seq_pkg::*;
#(
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned PAGE_W    = 6,
  parameter int unsigned ERASE_CYC = 420000,
  parameter int unsigned PROG_CYC  = 8000,
  parameter int unsigned CNT_W     = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [3:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic              busy,
  output logic              tmr_load,
  output logic [CNT_W-1:0]  tmr_val,
  output logic              mem_en,
  output logic              mem_we,
  output logic              mem_fill,
  output logic              mem_part,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              rd_pend,
  output logic              rd_part,
  output logic              wren,
  output logic              part,
  output logic              err,
  output logic              walk_active
);

  localparam int unsigned PGN_W = ADDR_W - PAGE_W;

  // command classification
  logic is_cmd, known, needs_wren, misalign, reject, accept;
  op_e  op;

  assign op         = op_e'(cmd_op);
  assign is_cmd     = cmd_valid && (cmd_op != OP_NOP);
  assign known      = (cmd_op <= OP_SWRST);
  assign needs_wren = (op == OP_PG_ERASE) || (op == OP_PT_ERASE) || (op == OP_PROG);
  assign misalign   = (op == OP_PG_ERASE) && (cmd_addr[PAGE_W-1:0] != '0);
  assign reject     = is_cmd && (busy || !known || (needs_wren && !wren) || misalign);
  assign accept     = is_cmd && !reject;

  logic acc_wren, acc_hi, acc_lo, acc_pg, acc_pt, acc_prog, acc_read, acc_rst;
  assign acc_wren = accept && (op == OP_WREN);
  assign acc_hi   = accept && (op == OP_SEL_HI);
  assign acc_lo   = accept && (op == OP_SEL_LO);
  assign acc_pg   = accept && (op == OP_PG_ERASE);
  assign acc_pt   = accept && (op == OP_PT_ERASE);
  assign acc_prog = accept && (op == OP_PROG);
  assign acc_read = accept && (op == OP_READ);
  assign acc_rst  = accept && (op == OP_SWRST);

  // state registers
  logic              wren_q, wren_d;
  logic              part_q, part_d;
  logic              err_q, err_d;
  walk_e             walk_q, walk_d;
  logic [ADDR_W-1:0] wptr_q, wptr_d;
  logic [PGN_W-1:0]  wpg_q, wpg_d;
  logic              wpart_q, wpart_d;
  logic              rdp_q, rdp_d;
  logic              rdpart_q, rdpart_d;
  logic              walk_last;

  assign walk_last = (walk_q == WK_PAGE) ? (wptr_q[PAGE_W-1:0] == '1)
                                         : (wptr_q == '1);

  always_comb begin
    wren_d   = wren_q;
    part_d   = part_q;
    err_d    = err_q;
    walk_d   = walk_q;
    wptr_d   = wptr_q;
    wpg_d    = wpg_q;
    wpart_d  = wpart_q;
    rdp_d    = acc_read;
    rdpart_d = acc_read ? part_q : rdpart_q;

    if (acc_wren) wren_d = 1'b1;
    if (acc_rst)  wren_d = 1'b0;

    if (acc_hi)            part_d = 1'b1;
    if (acc_lo || acc_rst) part_d = 1'b0;

    if (reject)       err_d = 1'b1;
    else if (acc_rst) err_d = 1'b0;

    if (acc_pg || acc_pt) begin
      walk_d  = acc_pg ? WK_PAGE : WK_PART;
      wptr_d  = '0;
      wpg_d   = cmd_addr[ADDR_W-1:PAGE_W];
      wpart_d = part_q;
    end else if (walk_q != WK_IDLE) begin
      wptr_d = wptr_q + 1'b1;
      if (walk_last) walk_d = WK_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wren_q   <= 1'b0;
      part_q   <= 1'b0;
      err_q    <= 1'b0;
      walk_q   <= WK_IDLE;
      wptr_q   <= '0;
      wpg_q    <= '0;
      wpart_q  <= 1'b0;
      rdp_q    <= 1'b0;
      rdpart_q <= 1'b0;
    end else begin
      wren_q   <= wren_d;
      part_q   <= part_d;
      err_q    <= err_d;
      walk_q   <= walk_d;
      wptr_q   <= wptr_d;
      wpg_q    <= wpg_d;
      wpart_q  <= wpart_d;
      rdp_q    <= rdp_d;
      rdpart_q <= rdpart_d;
    end
  end

  // timer and array drive
  logic [ADDR_W-1:0] walk_addr;
  assign walk_active = (walk_q != WK_IDLE);
  assign walk_addr   = (walk_q == WK_PAGE) ? {wpg_q, wptr_q[PAGE_W-1:0]} : wptr_q;

  assign tmr_load = acc_pg || acc_pt || acc_prog;
  assign tmr_val  = acc_prog ? CNT_W'(PROG_CYC) : CNT_W'(ERASE_CYC);

  assign mem_en   = walk_active || acc_prog || acc_read;
  assign mem_we   = walk_active || acc_prog;
  assign mem_fill = walk_active;
  assign mem_part = walk_active ? wpart_q : part_q;
  assign mem_addr = walk_active ? walk_addr : cmd_addr;

  assign rd_pend = rdp_q;
  assign rd_part = rdpart_q;
  assign wren    = wren_q;
  assign part    = part_q;
  assign err     = err_q;

endmodule

// File: rtl/flash_seq_top.sv
module flash_seq_top
  import flash_seq_pkg::*;
#(
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned PAGE_W    = 6,
  parameter int unsigned ERASE_CYC = 420000,
  parameter int unsigned PROG_CYC  = 8000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_valid,
  input  logic [3:0]  cmd_op,
  input  logic [15:0] cmd_addr,
  input  logic [7:0]  cmd_data,
  output logic        busy,
  output logic        err,
  output logic        wren_flag,
  output logic        part_sel,
  output logic [7:0]  rdata
);

  localparam int unsigned MAX_CYC = (ERASE_CYC > PROG_CYC) ? ERASE_CYC : PROG_CYC;
  localparam int unsigned CNT_W   = $clog2(MAX_CYC + 1);

  logic              tmr_load;
  logic [CNT_W-1:0]  tmr_val;
  logic              mem_en, mem_we, mem_fill, mem_part;
  logic [ADDR_W-1:0] mem_addr;
  logic              rd_pend, rd_part;
  logic              walk_active;
  logic [7:0]        bank_q [NUM_PART];
  logic [7:0]        rdata_q, rdata_d;
  logic              unused_addr_hi;

  assign unused_addr_hi = ^cmd_addr[15:ADDR_W];

  flash_seq_ctrl #(
    .ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .ERASE_CYC(ERASE_CYC),
    .PROG_CYC(PROG_CYC), .CNT_W(CNT_W)
  ) i_ctrl (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_addr(cmd_addr[ADDR_W-1:0]),
    .busy(busy),
    .tmr_load(tmr_load), .tmr_val(tmr_val),
    .mem_en(mem_en), .mem_we(mem_we), .mem_fill(mem_fill),
    .mem_part(mem_part), .mem_addr(mem_addr),
    .rd_pend(rd_pend), .rd_part(rd_part),
    .wren(wren_flag), .part(part_sel), .err(err),
    .walk_active(walk_active)
  );

  flash_busy_timer #(.CNT_W(CNT_W)) i_timer (
    .clk(clk), .rst_n(rst_n),
    .load(tmr_load), .load_val(tmr_val), .busy(busy)
  );

  for (genvar p = 0; p < NUM_PART; p++) begin : g_bank
    logic bank_en;
    assign bank_en = mem_en && (mem_part == p[0]);
    flash_bank #(.ADDR_W(ADDR_W), .DATA_W(8)) i_bank (
      .clk(clk), .rst_n(rst_n),
      .en(bank_en), .we(mem_we), .fill(mem_fill),
      .addr(mem_addr), .wdata(cmd_data), .rdata(bank_q[p])
    );
  end

  always_comb begin
    rdata_d = rdata_q;
    if (rd_pend) rdata_d = bank_q[rd_part];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata_q <= '0;
    else        rdata_q <= rdata_d;
  end

  assign rdata = rdata_q;

endmodule

// File: rtl/flash_seq_chk.sv
module flash_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_valid,
  input logic [3:0] cmd_op,
  input logic       busy,
  input logic       err,
  input logic       wren_flag,
  input logic       part_sel,
  input logic       walk_active
);

  p_busy_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    busy && cmd_valid && (cmd_op != 4'd0) |=> err);

  p_err_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    err && !(cmd_valid && (cmd_op == 4'd8)) |=> err);

  p_erase_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && wren_flag && cmd_valid && (cmd_op == 4'd5) |=> busy);

  p_sel_hi_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && cmd_valid && (cmd_op == 4'd2) |=> part_sel);

  p_wren_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !wren_flag && cmd_valid && (cmd_op == 4'd6) |=> err && !busy);

  p_swrst_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && cmd_valid && (cmd_op == 4'd8) |=> !wren_flag && !err && !part_sel);

  p_walk_in_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    walk_active |-> busy);

endmodule

bind flash_seq_top flash_seq_chk i_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
  .busy(busy), .err(err), .wren_flag(wren_flag), .part_sel(part_sel),
  .walk_active(walk_active)
);

// File: tb/test_flash_seq_top.sv
module test_flash_seq_top;

  localparam int AW    = 6;
  localparam int PW    = 3;
  localparam int DEPTH = 1 << AW;
  localparam int ECYC  = 80;
  localparam int PCYC  = 6;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cmd_valid;
  logic [3:0]  cmd_op;
  logic [15:0] cmd_addr;
  logic [7:0]  cmd_data;
  logic        busy, err, wren_flag, part_sel;
  logic [7:0]  rdata;

  int n_chk  = 0;
  int n_fail = 0;
  logic [7:0] mdl [2][DEPTH];

  always #5 clk = ~clk;

  flash_seq_top #(.ADDR_W(AW), .PAGE_W(PW), .ERASE_CYC(ECYC), .PROG_CYC(PCYC)) i_flash_seq_top (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_data(cmd_data), .busy(busy), .err(err),
    .wren_flag(wren_flag), .part_sel(part_sel), .rdata(rdata)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cmd(input logic [3:0] op, input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_addr = a; cmd_data = d;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_op = 4'd0;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  task automatic busy_len(output int n);
    n = 0;
    while (busy) begin n++; @(negedge clk); end
  endtask

  task automatic rd(input logic [15:0] a, output logic [7:0] d);
    cmd(4'd7, a, 8'h00);
    @(negedge clk);
    d = rdata;
  endtask

  task automatic sweep(input string req);
    logic [7:0] v;
    for (int p = 0; p < 2; p++) begin
      cmd((p == 1) ? 4'd2 : 4'd3, 16'h0, 8'h0);
      for (int a = 0; a < DEPTH; a++) begin
        rd(16'(a), v);
        chk(req, int'(v), int'(mdl[p][a]));
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog R1: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int n;
    logic [7:0] v;
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_op = 4'd0; cmd_addr = '0; cmd_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 busy", int'(busy), 0);
    chk("R1 err", int'(err), 0);
    chk("R1 wren", int'(wren_flag), 0);
    chk("R1 part", int'(part_sel), 0);
    chk("R1 rdata", int'(rdata), 0);

    // R9 program without write-enable is rejected
    cmd(4'd6, 16'd5, 8'h00);
    chk("R9 err", int'(err), 1);
    chk("R9 busy", int'(busy), 0);
    cmd(4'd1, 16'h0, 8'h0);
    chk("R9 wren", int'(wren_flag), 1);
    // R10 software reset clears flags
    cmd(4'd8, 16'h0, 8'h0);
    chk("R10 err", int'(err), 0);
    chk("R10 wren", int'(wren_flag), 0);
    cmd(4'd1, 16'h0, 8'h0);

    // R5/R6 partition 0 erase with exact busy length
    cmd(4'd5, 16'h0, 8'h0);
    busy_len(n);
    chk("R6 erase busy cycles", n, ECYC);
    // R6 command during busy is dropped
    cmd(4'd2, 16'h0, 8'h0);
    chk("R7 select high", int'(part_sel), 1);
    cmd(4'd5, 16'h0, 8'h0);
    cmd(4'd3, 16'h0, 8'h0);
    chk("R6 dropped select", int'(part_sel), 1);
    chk("R6 err set", int'(err), 1);
    wait_idle();
    chk("R6 err sticky", int'(err), 1);
    cmd(4'd8, 16'h0, 8'h0);
    chk("R10 part", int'(part_sel), 0);
    cmd(4'd1, 16'h0, 8'h0);
    for (int p = 0; p < 2; p++)
      for (int a = 0; a < DEPTH; a++) mdl[p][a] = 8'hFF;
    sweep("R5 erased");

    // R3/R2 two programming passes, upper address bits set
    for (int pass = 0; pass < 2; pass++) begin
      for (int p = 0; p < 2; p++) begin
        cmd((p == 1) ? 4'd2 : 4'd3, 16'h0, 8'h0);
        for (int a = 0; a < DEPTH; a++) begin
          logic [7:0] d;
          d = (pass == 0) ? 8'(a * 37 + p * 91 + 13) : ~8'(a * 5 + p);
          cmd(4'd6, 16'hA5C0 | 16'(a), d);
          mdl[p][a] = mdl[p][a] & d;
          if (a == 0 && p == 0 && pass == 0) begin
            busy_len(n);
            chk("R3 program busy cycles", n, PCYC);
          end
          wait_idle();
        end
      end
    end
    sweep("R3 R2 programmed");

    // R4 page erase of page 2 in partition 1
    cmd(4'd2, 16'h0, 8'h0);
    cmd(4'd4, 16'hFFC0 | 16'(2 << PW), 8'h0);
    busy_len(n);
    chk("R4 page erase busy", n, ECYC);
    for (int a = 0; a < (1 << PW); a++) mdl[1][(2 << PW) + a] = 8'hFF;
    // R4 misaligned page erase rejected
    cmd(4'd4, 16'(5 << PW) + 16'd1, 8'h0);
    chk("R4 misaligned err", int'(err), 1);
    chk("R4 misaligned busy", int'(busy), 0);
    cmd(4'd8, 16'h0, 8'h0);
    cmd(4'd1, 16'h0, 8'h0);
    sweep("R4 page erase");

    // R5 erase partition 0 only
    cmd(4'd3, 16'h0, 8'h0);
    cmd(4'd5, 16'h0, 8'h0);
    wait_idle();
    for (int a = 0; a < DEPTH; a++) mdl[0][a] = 8'hFF;
    sweep("R5 R7 R8 one partition");

    // R9 after software reset a program leaves the byte unchanged
    cmd(4'd8, 16'h0, 8'h0);
    cmd(4'd6, 16'd3, 8'h00);
    chk("R9 rejected err", int'(err), 1);
    rd(16'd3, v);
    chk("R9 byte unchanged", int'(v), 8'hFF);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule